// File: doc/BRIEF.md
# Square-Wave Tune Sequencer

The block plays one stored tune at a time as a single-tone square wave on one output pin. Software sets a tune number, a play mode and a tempo step, then raises a play bit. The block looks up the tune's first note address in a small tune table. It then walks a shared note store one word at a time. Each note word holds a pitch divider, a length code and an end-of-tune flag. Both stores sit outside the block as synchronous-read memories, so the block only drives their addresses and takes their data back.

There are two play modes. In level-hold mode the tune repeats for as long as the play bit is held, and clearing the bit silences the pin at once. In one-shot mode a single rising edge of the play bit runs the tune once. A one-cycle completion pulse marks the end of each pass through a tune. An optional hop input lets a new tune number take over at the next note boundary.

Top module: `tone_seq`

## Requirements
- R1: During and right after synchronous reset, `tone_out` and `done_irq` are low.
- R2: A start is a rising edge of `play` sampled while idle. At that edge `tune_sel`, `tempo_sel` and `one_shot` are latched. The tune table word at index `tune_sel` is the note address of the tune's first note. Counting the start edge as edge 0, the first rising edge of `tone_out` happens on edge 5+D, where D is the first note's divider (D > 0).
- R3: A note word is 12 bits. Bits [11:4] hold the divider. Bits [3:1] hold the length code, where codes 0..7 mean 1, 2, 3, 4, 6, 8, 12 and 16 sixteenth-beats. Bit 0 set marks the tune's last note.
- R4: Each note starts with `tone_out` low. While the note plays, `tone_out` toggles every D+1 clock cycles. A divider of 0 is a rest, and `tone_out` stays low for the whole note.
- R5: A note plays for L × SIXT_CYC × 2^`tempo_sel` clock cycles, where L is its length in sixteenth-beats. Consecutive notes are separated by 2 fetch cycles. For a tune of N notes with total play time S, the completion pulse follows edge 4+S+2(N−1) after the start edge.
- R6: In one-shot mode, `done_irq` is high for exactly one cycle after the last note and the block returns to idle. Clearing `play` during the tune has no effect. Holding `play` high afterwards does not start the tune again.
- R7: In level-hold mode the tune restarts from its first note after the last note, with a pulse on `done_irq` each pass; one pass lasts S+2N cycles. Sampling `play` low in any busy state stops the tune without a pulse, and `tone_out` is low from the second edge on.
- R8: When `hop_en` is high and `tune_sel` differs from the playing tune at a note boundary, the new tune begins as if started at that edge. This takes priority over the end of the tune, so no pulse is raised there.
- R9: When `hop_en` is low, changes of `tune_sel` during play are ignored.
- R10: While idle, `tone_out` stays low.
- R11: `tab_addr` and `note_addr` come straight from registers. The block uses memory data one clock after the address edge, which matches a synchronous-read memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| play | input | 1 | Play control bit |
| one_shot | input | 1 | 1 selects one-shot mode, 0 selects level-hold mode |
| hop_en | input | 1 | Allows a tune change at note boundaries |
| tune_sel | input | 4 | Tune number |
| tempo_sel | input | 2 | Tempo step; the sixteenth-beat lasts SIXT_CYC << tempo_sel cycles |
| tab_addr | output | 4 | Tune table address |
| tab_data | input | 9 | Tune table data: the first note address |
| note_addr | output | 9 | Note store address |
| note_data | input | 12 | Note store data |
| tone_out | output | 1 | Square-wave output |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall on the same edge: a tune's last note ending and a pending hop to another tune. The bench provokes this by starting a one-note tune with hop enabled and changing `tune_sel` partway through that note. It then checks that no pulse appears at that boundary and that the only pulse comes at the end of the hopped-to tune, on the exact cycle R5 predicts. The same overlap exists between a level-hold stop and the end of a tune. The bench also compares a hop from a note that is not the last against the same stimulus with hop disabled.

// File: rtl/tseq_pkg.sv
package tseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TWAIT,
    S_TLOAD,
    S_NWAIT,
    S_NLOAD,
    S_PLAY
  } seq_st_t;

  localparam int LCODE_W = 3;
  localparam int L16_W   = 5;

  // length code -> sixteenth-beats
  function automatic logic [L16_W-1:0] len_sixteenths(input logic [LCODE_W-1:0] code);
    logic [L16_W-1:0] r;
    case (code)
      3'd0:    r = 5'd1;
      3'd1:    r = 5'd2;
      3'd2:    r = 5'd3;
      3'd3:    r = 5'd4;
      3'd4:    r = 5'd6;
      3'd5:    r = 5'd8;
      3'd6:    r = 5'd12;
      default: r = 5'd16;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tseq_tone.sv
module tseq_tone #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tone
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tone <= 1'b0;
    end else if (div == '0) begin
      cnt  <= '0;
      tone <= 1'b0;
    end else if (cnt == div) begin
      cnt  <= '0;
      tone <= ~tone;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

endmodule

// File: rtl/tseq_beat.sv
module tseq_beat #(
  parameter int SIXT_CYC = 256,
  parameter int TEMPO_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic [TEMPO_W-1:0]       tempo,
  input  logic [tseq_pkg::L16_W-1:0] len16,
  output logic                     note_end
);

  localparam int PRE_MAX = SIXT_CYC << ((1 << TEMPO_W) - 1);
  localparam int PRE_W   = $clog2(PRE_MAX + 1);
  localparam int L_W     = tseq_pkg::L16_W;

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] lim;
  logic [L_W-1:0]   n16;
  logic             tick;

  always_comb begin
    lim  = PRE_W'(SIXT_CYC) << tempo;
    tick = (pre == lim - PRE_W'(1));
    note_end = en && tick && (n16 == len16 - L_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pre <= '0;
      n16 <= '0;
    end else if (tick) begin
      pre <= '0;
      n16 <= n16 + L_W'(1);
    end else begin
      pre <= pre + PRE_W'(1);
    end
  end

endmodule

// File: rtl/tseq_ctrl.sv
module tseq_ctrl #(
  parameter int TUNE_W  = 4,
  parameter int NADDR_W = 9,
  parameter int DIV_W   = 8,
  parameter int TEMPO_W = 2,
  parameter int NOTE_W  = DIV_W + 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  play,
  input  logic                  one_shot,
  input  logic                  hop_en,
  input  logic [TUNE_W-1:0]     tune_sel,
  input  logic [TEMPO_W-1:0]    tempo_sel,
  input  logic [NADDR_W-1:0]    tab_data,
  input  logic [NOTE_W-1:0]     note_data,
  input  logic                  note_end,
  output tseq_pkg::seq_st_t     st,
  output logic [TUNE_W-1:0]     cur_tune,
  output logic [NADDR_W-1:0]    ptr,
  output logic [DIV_W-1:0]      div_q,
  output logic [tseq_pkg::LCODE_W-1:0] lcode_q,
  output logic [TEMPO_W-1:0]    tempo_q,
  output logic                  oneshot_q,
  output logic                  done_irq
);
  import tseq_pkg::*;

  logic               play_q;
  logic               last_q;
  logic [NADDR_W-1:0] base;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      play_q    <= 1'b0;
      cur_tune  <= '0;
      ptr       <= '0;
      base      <= '0;
      div_q     <= '0;
      lcode_q   <= '0;
      last_q    <= 1'b0;
      tempo_q   <= '0;
      oneshot_q <= 1'b0;
      done_irq  <= 1'b0;
    end else begin
      play_q   <= play;
      done_irq <= 1'b0;
      if (st != S_IDLE && !oneshot_q && !play) begin
        st <= S_IDLE;                       // level-hold stop wins over all
      end else begin
        case (st)
          S_IDLE: begin
            if (play && !play_q) begin
              cur_tune  <= tune_sel;
              tempo_q   <= tempo_sel;
              oneshot_q <= one_shot;
              st        <= S_TWAIT;
            end
          end
          S_TWAIT: st <= S_TLOAD;
          S_TLOAD: begin
            base <= tab_data;
            ptr  <= tab_data;
            st   <= S_NWAIT;
          end
          S_NWAIT: st <= S_NLOAD;
          S_NLOAD: begin
            div_q   <= note_data[NOTE_W-1 -: DIV_W];
            lcode_q <= note_data[3:1];
            last_q  <= note_data[0];
            st      <= S_PLAY;
          end
          S_PLAY: begin
            if (note_end) begin
              if (hop_en && (tune_sel != cur_tune)) begin
                cur_tune <= tune_sel;
                st       <= S_TWAIT;
              end else if (last_q) begin
                done_irq <= 1'b1;
                if (oneshot_q) begin
                  st <= S_IDLE;
                end else begin
                  ptr <= base;
                  st  <= S_NWAIT;
                end
              end else begin
                ptr <= ptr + NADDR_W'(1);
                st  <= S_NWAIT;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/tone_seq.sv
module tone_seq #(
  parameter int TUNES      = 16,
  parameter int NOTE_DEPTH = 495,
  parameter int DIV_W      = 8,
  parameter int SIXT_CYC   = 256,
  parameter int TEMPO_W    = 2,
  localparam int TUNE_W    = $clog2(TUNES),
  localparam int NADDR_W   = $clog2(NOTE_DEPTH),
  localparam int NOTE_W    = DIV_W + 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               play,
  input  logic               one_shot,
  input  logic               hop_en,
  input  logic [TUNE_W-1:0]  tune_sel,
  input  logic [TEMPO_W-1:0] tempo_sel,
  output logic [TUNE_W-1:0]  tab_addr,
  input  logic [NADDR_W-1:0] tab_data,
  output logic [NADDR_W-1:0] note_addr,
  input  logic [NOTE_W-1:0]  note_data,
  output logic               tone_out,
  output logic               done_irq
);
  import tseq_pkg::*;

  seq_st_t              st;
  logic [DIV_W-1:0]     div_q;
  logic [LCODE_W-1:0]   lcode_q;
  logic [TEMPO_W-1:0]   tempo_q;
  logic                 oneshot_q;
  logic                 note_end;
  logic                 play_en;
  logic [L16_W-1:0]     len16;

  always_comb begin
    play_en = (st == S_PLAY);
    len16   = len_sixteenths(lcode_q);
  end

  tseq_ctrl #(
    .TUNE_W (TUNE_W),
    .NADDR_W(NADDR_W),
    .DIV_W  (DIV_W),
    .TEMPO_W(TEMPO_W),
    .NOTE_W (NOTE_W)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .play     (play),
    .one_shot (one_shot),
    .hop_en   (hop_en),
    .tune_sel (tune_sel),
    .tempo_sel(tempo_sel),
    .tab_data (tab_data),
    .note_data(note_data),
    .note_end (note_end),
    .st       (st),
    .cur_tune (tab_addr),
    .ptr      (note_addr),
    .div_q    (div_q),
    .lcode_q  (lcode_q),
    .tempo_q  (tempo_q),
    .oneshot_q(oneshot_q),
    .done_irq (done_irq)
  );

  tseq_beat #(
    .SIXT_CYC(SIXT_CYC),
    .TEMPO_W (TEMPO_W)
  ) beat_i (
    .clk     (clk),
    .rst     (rst),
    .en      (play_en),
    .tempo   (tempo_q),
    .len16   (len16),
    .note_end(note_end)
  );

  tseq_tone #(
    .DIV_W(DIV_W)
  ) tone_i (
    .clk (clk),
    .rst (rst),
    .en  (play_en),
    .div (div_q),
    .tone(tone_out)
  );

endmodule

// File: rtl/tone_seq_chk.sv
module tone_seq_chk #(
  parameter int DIV_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  play,
  input logic                  tone_out,
  input logic                  done_irq,
  input tseq_pkg::seq_st_t     st,
  input logic                  oneshot_q,
  input logic [DIV_W-1:0]      div_q
);
  import tseq_pkg::*;

  // R6: completion is a single-cycle pulse
  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);

  // R6: a pulse only follows a playing note
  assert_irq_src_R6: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> ($past(st) == S_PLAY));

  // R7: level-hold stop from any busy state
  assert_level_stop_R7: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE && !oneshot_q && !play) |=> (st == S_IDLE));

  // R10: idle keeps the pin low
  assert_idle_low_R10: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && $past(st) == S_IDLE) |-> !tone_out);

  // R4: a rest note keeps the pin low
  assert_rest_low_R4: assert property (@(posedge clk) disable iff (rst)
    (st == S_PLAY && div_q == '0) |-> !tone_out);

  // R2: a rising play edge in idle starts the table lookup
  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && $rose(play)) |=> (st == S_TWAIT));

endmodule

bind tone_seq tone_seq_chk #(.DIV_W(DIV_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .play     (play),
  .tone_out (tone_out),
  .done_irq (done_irq),
  .st       (st),
  .oneshot_q(oneshot_q),
  .div_q    (div_q)
);

// File: tb/tone_seq_tb_top.sv
`timescale 1ns/1ps
module tone_seq_tb_top;

  localparam int SIXT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        play = 1'b0;
  logic        one_shot = 1'b1;
  logic        hop_en = 1'b0;
  logic [3:0]  tune_sel = '0;
  logic [1:0]  tempo_sel = '0;
  logic [3:0]  tab_addr;
  logic [8:0]  tab_data;
  logic [8:0]  note_addr;
  logic [11:0] note_data;
  logic        tone_out;
  logic        done_irq;

  always #4 clk = ~clk;

  tone_seq #(.SIXT_CYC(SIXT)) dut_i (
    .clk(clk), .rst(rst), .play(play), .one_shot(one_shot), .hop_en(hop_en),
    .tune_sel(tune_sel), .tempo_sel(tempo_sel),
    .tab_addr(tab_addr), .tab_data(tab_data),
    .note_addr(note_addr), .note_data(note_data),
    .tone_out(tone_out), .done_irq(done_irq)
  );

  // synchronous-read memory models (R11)
  logic [8:0]  tab_mem  [16];
  logic [11:0] note_mem [495];
  always_ff @(posedge clk) begin
    tab_data  <= tab_mem[tab_addr];
    note_data <= note_mem[note_addr];
  end

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  int r_irq1, r_irq2, r_nirq, r_rise, r_fall, r_hi;

  typedef struct packed {
    logic [3:0] tune;
    logic [1:0] tempo;
    logic [7:0] half;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{4'd0, 2'd0, 8'd0},
    '{4'd2, 2'd0, 8'd3},
    '{4'd1, 2'd1, 8'd2},
    '{4'd2, 2'd2, 8'd3},
    '{4'd1, 2'd3, 8'd2}
  };

  function automatic logic [11:0] mk(input int dv, input int code, input int last);
    return {8'(dv), 3'(code), 1'(last)};
  endfunction

  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'd0: return 1;  3'd1: return 2;  3'd2: return 3;  3'd3: return 4;
      3'd4: return 6;  3'd5: return 8;  3'd6: return 12; default: return 16;
    endcase
  endfunction

  // edge index of the completion pulse, counted from the start edge (R5)
  function automatic int exp_k(input int t, input int tempo);
    int a = int'(tab_mem[t]);
    int s = 0;
    int n = 0;
    for (int i = 0; i < 64; i++) begin
      s += len_of(note_mem[a][3:1]) * (SIXT << tempo);
      n++;
      if (note_mem[a][0]) break;
      a++;
    end
    return 4 + s + 2 * (n - 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Raises play at a negedge; sample i is taken after edge i-1 from the start edge.
  task automatic run(input int limit, input int drop_at, input int sel_at,
                     input logic [3:0] sel_new, input int w0, input int w1);
    logic prev = 1'b0;
    r_irq1 = 0; r_irq2 = 0; r_nirq = 0; r_rise = 0; r_fall = 0; r_hi = 0;
    @(negedge clk);
    play = 1'b1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (tone_out && !prev && r_rise == 0) r_rise = i;
      else if (!tone_out && prev && r_rise != 0 && r_fall == 0) r_fall = i;
      prev = tone_out;
      if (tone_out && i >= w0 && i <= w1) r_hi++;
      if (done_irq) begin
        r_nirq++;
        if (r_irq1 == 0) r_irq1 = i;
        else if (r_irq2 == 0) r_irq2 = i;
      end
      if (i == drop_at) play = 1'b0;
      if (i == sel_at) tune_sel = sel_new;
    end
    play = 1'b0;
    hop_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) tab_mem[i] = '0;
    for (int i = 0; i < 495; i++) note_mem[i] = '0;
    tab_mem[0] = 9'd0;  tab_mem[1] = 9'd8;  tab_mem[2] = 9'd16; tab_mem[3] = 9'd32;
    note_mem[0]  = mk(3, 0, 0);  note_mem[1]  = mk(0, 1, 0);  note_mem[2] = mk(5, 2, 1);
    note_mem[8]  = mk(1, 7, 1);
    note_mem[16] = mk(2, 3, 0);  note_mem[17] = mk(2, 4, 0);
    note_mem[18] = mk(2, 5, 0);  note_mem[19] = mk(4, 6, 1);
    note_mem[32] = mk(7, 7, 0);  note_mem[33] = mk(7, 7, 1);

    repeat (3) @(negedge clk);
    chk("R1 tone_out in reset", int'(tone_out), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done_irq after reset", int'(done_irq), 0);
    begin
      int hi = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (tone_out) hi++;
      end
      chk("R10 idle output stays low", hi, 0);
    end

    // table walk: one-shot runs at several tunes and tempo steps
    for (int v = 0; v < 5; v++) begin
      int e, d0;
      e  = exp_k(int'(VECS[v].tune), int'(VECS[v].tempo)) + 1;
      d0 = int'(note_mem[tab_mem[VECS[v].tune]][11:4]);
      one_shot  = 1'b1;
      tune_sel  = VECS[v].tune;
      tempo_sel = VECS[v].tempo;
      run(e + 30, 0, 0, 4'd0, e + 1, e + 30);
      chk("R5 R3 R11 completion cycle", r_irq1, e);
      chk("R2 R3 first rise cycle", r_rise, 6 + d0);
      if (VECS[v].half != 0) chk("R4 half period", r_fall - r_rise, int'(VECS[v].half));
      chk("R6 single pulse, no restart", r_nirq, 1);
      chk("R6 silent after completion", r_hi, 0);
    end

    // rest note low and one-shot ignores a play drop
    one_shot = 1'b1; tune_sel = 4'd0; tempo_sel = 2'd0;
    run(60, 3, 0, 4'd0, 10, 19);
    chk("R4 rest note low", r_hi, 0);
    chk("R6 play drop ignored in one-shot", r_irq1, 33);

    // level-hold repeat
    one_shot = 1'b0; tune_sel = 4'd0; tempo_sel = 2'd0;
    run(70, 0, 0, 4'd0, 0, 0);
    chk("R7 first pass pulse", r_irq1, 33);
    chk("R7 second pass pulse", r_irq2, 63);

    // level-hold stop mid note
    one_shot = 1'b0; tune_sel = 4'd1; tempo_sel = 2'd0;
    run(100, 20, 0, 4'd0, 22, 100);
    chk("R7 sound before stop", r_rise, 7);
    chk("R7 low after stop", r_hi, 0);
    chk("R7 no pulse on stop", r_nirq, 0);

    // hop from a middle note
    one_shot = 1'b1; hop_en = 1'b1; tune_sel = 4'd3; tempo_sel = 2'd0;
    run(160, 0, 10, 4'd1, 0, 0);
    chk("R8 hop mid tune completion", r_irq1, 137);
    chk("R8 hop mid tune pulse count", r_nirq, 1);

    // hop coinciding with the last note's end
    one_shot = 1'b1; hop_en = 1'b1; tune_sel = 4'd1; tempo_sel = 2'd0;
    run(120, 0, 10, 4'd0, 0, 0);
    chk("R8 hop beats end of tune", r_irq1, 101);
    chk("R8 one pulse only", r_nirq, 1);

    // hop disabled
    one_shot = 1'b1; hop_en = 1'b0; tune_sel = 4'd3; tempo_sel = 2'd0;
    run(160, 0, 10, 4'd1, 0, 0);
    chk("R9 tune change ignored", r_irq1, 135);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule